// File: doc/BRIEF.md
# Programmable-Format Serial Port with Byte Queues

This block is a full-duplex asynchronous serial port. A 16-bit divisor sets the baud rate by producing a sample tick at sixteen times the bit rate. The same tick times both the transmitter and the receiver. Each direction holds its bytes in a 16-entry queue. The frame is set by plain configuration pins:
- 5 to 8 data bits;
- parity on or off, even or odd;
- one, one-and-a-half or two stop bits.

Bytes to send enter through a valid/ready stream. `tx_ready` is high exactly when the transmit queue has a free slot. A byte is accepted on a rising clock edge where both `tx_valid` and `tx_ready` are high. While `tx_ready` is low the producer must hold `tx_valid` and `tx_data` steady.

Received bytes leave through a second valid/ready stream. `rx_valid` is high while the receive queue holds a byte. The head entry, with its parity and framing error bits, is removed on a rising edge where `rx_valid` and `rx_ready` are both high. A consumer that holds `rx_ready` low lets the queue fill. Once the queue is full, any further byte received is lost and the block records an overrun. A level interrupt reports two queue conditions, not single bytes: receive data waiting, and transmit queue empty.

Top module: `uart_fmt`

## Requirements
- R1: The sample tick comes once every max(`divisor`,1) clocks, so a divisor of 0 behaves as 1. A change of `divisor` restarts the tick count. Every bit, the start bit included, lasts 16 ticks on `txd`.
- R2: The line idles high. A frame is sent as a low start bit, then the data bits least significant first, then the parity bit if enabled, then high stop bits.
- R3: `cfg_len` sets the data length to 5 + `cfg_len` bits (0 gives 5 bits, 3 gives 8 bits). The transmitter ignores the unused upper bits of `tx_data`. The receiver returns them as zero in `rx_data`.
- R4: With `cfg_par_en`=1, a parity bit is sent. It is the XOR of the configured data bits only, inverted when `cfg_par_odd`=1 (so 0 selects even parity). The receiver sets `rx_par_err` on an entry whose parity bit does not match.
- R5: `cfg_stop` selects the stop length:
  - 0 gives one bit;
  - 1 gives one and a half bits with 5-bit data, and one bit with any other length;
  - 2 or 3 gives two bits.
  With data queued, the start bits of consecutive frames are exactly (1 + data bits + parity bits) × 16 + stop ticks apart.
- R6: The transmit queue holds 16 bytes. `tx_ready` goes low when 16 are waiting, and `tx_empty` is high when none are waiting.
- R7: The receive queue holds 16 entries. A byte that arrives while the queue is full is dropped and sets `rx_overrun`. `rx_overrun` stays set until a `stat_rd` pulse clears it. The queued entries are kept unchanged.
- R8: The receiver samples the first stop bit at mid-bit. If it reads low, the entry is stored with `rx_frm_err`=1.
- R9: The receiver starts a frame only after a falling edge from high. The line must still be low 8 ticks later, otherwise the start is dropped. A low pulse shorter than half a bit therefore produces no entry.
- R10: `irq` = (`ien_rx` AND receive queue not empty) OR (`ien_tx` AND transmit queue empty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divisor | input | 16 | Baud divisor, clocks per sample tick |
| cfg_len | input | 2 | Data length code, bits = 5 + code |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop | input | 2 | Stop length code |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered on tx_data |
| tx_ready | output | 1 | Transmit queue has room |
| rx_data | output | 8 | Received byte, unused upper bits zero |
| rx_par_err | output | 1 | Parity error of the head entry |
| rx_frm_err | output | 1 | Framing error of the head entry |
| rx_valid | output | 1 | Receive queue holds an entry |
| rx_ready | input | 1 | Consumer takes the head entry |
| rx_overrun | output | 1 | Sticky flag: a byte was dropped |
| stat_rd | input | 1 | Status read pulse, clears rx_overrun |
| tx_empty | output | 1 | Transmit queue empty |
| ien_rx | input | 1 | Interrupt enable, data waiting |
| ien_tx | input | 1 | Interrupt enable, transmit queue empty |
| irq | output | 1 | Level interrupt |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |

## Verification
Parity is checked with 7-bit data whose eighth bit is set. A design that computes parity over the full byte sends the wrong bit there.

The spacing of start edges is measured for every stop code, 1.5-bit stops included, for both 5-bit and 8-bit data. A design that gives 1.5 stop bits for any data length, or that adds an idle tick between queued frames, produces the wrong spacing.

Bench-driven frames with a bad parity bit, a low stop bit and a short low glitch check three things:
- the error bits travel with the right byte;
- a broken stop bit does not start a false frame;
- a glitch is rejected.

Seventeen frames are sent into a stalled receive queue. A design that overwrites the queue, or that does not hold the overrun flag until the status read, fails this test.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;
  localparam int OVS  = 16;       // sample ticks per bit
  localparam int HALF = OVS / 2;  // start-bit confirm point

  typedef enum logic [2:0] {L_IDLE, L_START, L_DATA, L_PAR, L_STOP} line_st_t;

  function automatic logic [3:0] data_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  function automatic logic [7:0] keep_bits(input logic [7:0] d, input logic [1:0] len);
    return d & (8'hFF >> (2'd3 - len));
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] len, input logic odd);
    return (^keep_bits(d, len)) ^ odd;
  endfunction

  function automatic logic [5:0] stop_ticks(input logic [1:0] stop, input logic [1:0] len);
    if (stop == 2'd0) return 6'(OVS);
    if (stop == 2'd1) return (len == 2'd0) ? 6'(OVS + HALF) : 6'(OVS);
    return 6'(2 * OVS);
  endfunction
endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt, div_q, lim;
  logic             chg;

  assign lim  = (divisor == '0) ? DIV_W'(1) : divisor;
  assign chg  = (divisor != div_q);
  assign tick = !chg && (cnt == lim - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= '0;
    end else begin
      div_q <= divisor;
      cnt   <= (tick || chg) ? '0 : cnt + DIV_W'(1);
    end
  end

  // R1: with a divisor above one, ticks never come on adjacent clocks
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   FULLV = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == FULLV);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LASTP) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == LASTP) ? '0 : rp + AW'(1);
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  // R6: occupancy never exceeds the queue depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULLV);
  // R7: a push into a full queue with no pop leaves the occupancy unchanged
  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> $stable(cnt));
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [1:0] cfg_stop,
  input  logic       avail,
  input  logic [7:0] data,
  output logic       pop,
  output logic       txd
);
  localparam logic [3:0] SUB_END = 4'(OVS - 1);

  line_st_t   st;
  logic [3:0] sub, nb;
  logic [2:0] bitn;
  logic [5:0] stc, st_lim;
  logic [7:0] sh;
  logic       pbit, stop_end, last_bit;

  assign nb       = data_bits(cfg_len);
  assign st_lim   = stop_ticks(cfg_stop, cfg_len);
  assign last_bit = ({1'b0, bitn} == nb - 4'd1);
  assign stop_end = (st == L_STOP) && tick && (stc == st_lim - 6'd1);
  // a queued byte starts at a tick from idle, or right as a stop ends
  assign pop      = avail && (((st == L_IDLE) && tick) || stop_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= L_IDLE; sub <= '0; bitn <= '0; stc <= '0; sh <= '0; pbit <= 1'b0;
    end else if (pop) begin
      st   <= L_START;
      sub  <= '0;
      sh   <= data;
      pbit <= par_bit(data, cfg_len, cfg_par_odd);
    end else if (tick) begin
      case (st)
        L_START: if (sub == SUB_END) begin
          st <= L_DATA; sub <= '0; bitn <= '0;
        end else sub <= sub + 4'd1;
        L_DATA: if (sub == SUB_END) begin
          sub <= '0;
          sh  <= sh >> 1;
          if (last_bit) begin
            st  <= cfg_par_en ? L_PAR : L_STOP;
            stc <= '0;
          end else bitn <= bitn + 3'd1;
        end else sub <= sub + 4'd1;
        L_PAR: if (sub == SUB_END) begin
          st <= L_STOP; stc <= '0;
        end else sub <= sub + 4'd1;
        L_STOP: if (stop_end) st <= L_IDLE;
                else stc <= stc + 6'd1;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (st)
      L_START: txd = 1'b0;
      L_DATA:  txd = sh[0];
      L_PAR:   txd = pbit;
      default: txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       rxd,
  output logic       push,
  output logic [9:0] word
);
  localparam logic [3:0] SUB_END = 4'(OVS - 1);
  localparam logic [3:0] SUB_MID = 4'(HALF - 1);

  line_st_t   st;
  logic [1:0] rs;
  logic       rin, armed, pbad;
  logic [3:0] sub, nb;
  logic [2:0] bitn;
  logic [7:0] sh, got;

  assign rin = rs[1];
  assign nb  = data_bits(cfg_len);
  assign got = sh >> (4'd8 - nb);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs <= 2'b11; st <= L_IDLE; armed <= 1'b0; pbad <= 1'b0;
      sub <= '0; bitn <= '0; sh <= '0; push <= 1'b0; word <= '0;
    end else begin
      rs   <= {rs[0], rxd};
      push <= 1'b0;
      if (tick) begin
        case (st)
          L_IDLE: if (rin) armed <= 1'b1;
                  else if (armed) begin
                    st <= L_START; sub <= '0; pbad <= 1'b0;
                  end
          L_START: if (sub == SUB_MID) begin
            sub  <= '0; bitn <= '0;
            st   <= rin ? L_IDLE : L_DATA;
          end else sub <= sub + 4'd1;
          L_DATA: if (sub == SUB_END) begin
            sub <= '0;
            sh  <= {rin, sh[7:1]};
            if ({1'b0, bitn} == nb - 4'd1) st <= cfg_par_en ? L_PAR : L_STOP;
            else bitn <= bitn + 3'd1;
          end else sub <= sub + 4'd1;
          L_PAR: if (sub == SUB_END) begin
            sub  <= '0;
            pbad <= (rin != par_bit(got, cfg_len, cfg_par_odd));
            st   <= L_STOP;
          end else sub <= sub + 4'd1;
          L_STOP: if (sub == SUB_END) begin
            push  <= 1'b1;
            word  <= {!rin, pbad && cfg_par_en, got};
            armed <= 1'b0;  // wait for the line to return high
            st    <= L_IDLE;
          end else sub <= sub + 4'd1;
          default: st <= L_IDLE;
        endcase
      end
    end
  end

  // R9: a frame only begins from an armed idle line
  p_start_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == L_IDLE && $past(st) == L_STOP) |-> !armed);
endmodule

// File: rtl/uart_fmt.sv
module uart_fmt
  import uart_fmt_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic [1:0]       cfg_stop,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_par_err,
  output logic             rx_frm_err,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             rx_overrun,
  input  logic             stat_rd,
  output logic             tx_empty,
  input  logic             ien_rx,
  input  logic             ien_tx,
  output logic             irq,
  output logic             txd,
  input  logic             rxd
);
  localparam int RXW = 10;

  logic           tick, tx_full, tx_pop, tx_avail;
  logic [7:0]     tx_head;
  logic           rx_push, rx_empty, rx_full;
  logic [RXW-1:0] rx_word, rx_head;

  uart_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick));

  uart_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_valid), .din(tx_data),
    .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full));

  assign tx_ready = !tx_full;
  assign tx_avail = !tx_empty;

  uart_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
    .avail(tx_avail), .data(tx_head), .pop(tx_pop), .txd(txd));

  uart_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .rxd(rxd),
    .push(rx_push), .word(rx_word));

  uart_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
    .pop(rx_valid && rx_ready), .dout(rx_head), .empty(rx_empty), .full(rx_full));

  assign rx_valid   = !rx_empty;
  assign rx_data    = rx_head[7:0];
  assign rx_par_err = rx_head[8];
  assign rx_frm_err = rx_head[9];

  always_ff @(posedge clk) begin
    if (!rst_n)                 rx_overrun <= 1'b0;
    else if (rx_push && rx_full) rx_overrun <= 1'b1;
    else if (stat_rd)           rx_overrun <= 1'b0;
  end

  assign irq = (ien_rx && !rx_empty) || (ien_tx && tx_empty);

  // R2: taking a byte from the queue drives a low start bit next cycle
  p_pop_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !txd);
  // R7: overrun only rises after a byte arrived at a full queue
  p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(rx_push && rx_full));
endmodule

// File: tb/tb_uart_fmt.sv
module tb_uart_fmt;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic [1:0] cfg_len = 2'd3, cfg_stop = 2'd0;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic tx_valid = 1'b0, rx_ready = 1'b1, stat_rd = 1'b0;
  logic ien_rx = 1'b0, ien_tx = 1'b0, loop = 1'b1, drv = 1'b1;
  logic tx_ready, rx_par_err, rx_frm_err, rx_valid, rx_overrun, tx_empty, irq, txd, rxd;
  logic [7:0] rx_data;
  int total = 0, bad = 0, cyc = 0;
  logic [9:0] expq[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign rxd = loop ? txd : drv;

  uart_fmt dut (.clk(clk), .rst_n(rst_n), .divisor(divisor), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_overrun(rx_overrun), .stat_rd(stat_rd),
    .tx_empty(tx_empty), .ien_rx(ien_rx), .ien_tx(ien_tx), .irq(irq),
    .txd(txd), .rxd(rxd));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int bmask(input int len);
    return (1 << (len + 5)) - 1;
  endfunction

  // scoreboard monitor: R3 R4 R8 entries compared as {frm,par,data}
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (expq.size() == 0) chk("R3 unexpected rx entry", {rx_frm_err, rx_par_err, rx_data}, 0);
      else chk("R3/R4/R8 rx entry", {rx_frm_err, rx_par_err, rx_data}, expq.pop_front());
    end
  end

  task automatic push_tx(input logic [7:0] b, input bit expect_rx);
    tx_data = b; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    if (expect_rx) expq.push_back({2'b00, b & 8'(bmask(cfg_len))});
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 60) begin
      @(negedge clk);
      if (expq.size() == 0 && tx_empty && txd && !rx_valid) quiet++; else quiet = 0;
    end
  endtask

  task automatic cap(input int nb, input bit pe, output int data, output bit pb, output bit sv);
    data = 0; pb = 1'b0;
    while (txd !== 1'b0) @(negedge clk);
    repeat (8) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      repeat (16) @(negedge clk);
      data |= int'(txd) << k;
    end
    if (pe) begin repeat (16) @(negedge clk); pb = txd; end
    repeat (16) @(negedge clk);
    sv = txd;
  endtask

  task automatic frame_gap(input string tag, input int exp);
    int t0, t1;
    push_tx(8'h00, 1'b1); push_tx(8'h00, 1'b1);
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    while (txd !== 1'b1) @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    t1 = cyc;
    chk(tag, t1 - t0, exp);
    wait_idle();
  endtask

  task automatic send_ser(input logic [7:0] d, input bit badpar, input bit badstop);
    int nb = cfg_len + 5;
    logic [7:0] m = d & 8'(bmask(cfg_len));
    logic p = (^m) ^ cfg_par_odd ^ badpar;
    drv = 1'b0; repeat (16) @(negedge clk);
    for (int k = 0; k < nb; k++) begin drv = m[k]; repeat (16) @(negedge clk); end
    if (cfg_par_en) begin drv = p; repeat (16) @(negedge clk); end
    drv = !badstop; repeat (16) @(negedge clk);
    drv = 1'b1; repeat (16) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d, cnt; bit pb, sv;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 idle line high", txd, 1);
    chk("R6 tx_ready after reset", tx_ready, 1);
    chk("R6 tx_empty after reset", tx_empty, 1);
    chk("R7 rx_valid after reset", rx_valid, 0);
    chk("R10 irq disabled", irq, 0);
    ien_tx = 1'b1; @(negedge clk);
    chk("R10 irq on empty tx queue", irq, 1);
    ien_tx = 1'b0;

    // R1: start bit length tracks the divisor; 0 acts as 1
    divisor = 16'd3; repeat (4) @(negedge clk);
    push_tx(8'hFF, 1'b1);
    while (txd !== 1'b0) @(negedge clk);
    cnt = 0; while (txd === 1'b0) begin cnt++; @(negedge clk); end
    chk("R1 start bit at divisor 3", cnt, 48);
    wait_idle();
    divisor = 16'd0; repeat (4) @(negedge clk);
    push_tx(8'hFF, 1'b1);
    while (txd !== 1'b0) @(negedge clk);
    cnt = 0; while (txd === 1'b0) begin cnt++; @(negedge clk); end
    chk("R1 start bit at divisor 0", cnt, 16);
    wait_idle();
    divisor = 16'd1;

    // R2: bit order LSB first, stop high
    push_tx(8'hA5, 1'b1);
    cap(8, 1'b0, d, pb, sv);
    chk("R2 data LSB first", d, 8'hA5);
    chk("R2 stop bit high", sv, 1);
    wait_idle();

    // R4: parity over configured bits only (7-bit 0xFF has seven ones)
    cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    push_tx(8'hFF, 1'b1);
    cap(7, 1'b1, d, pb, sv);
    chk("R3 7-bit data sent", d, 8'h7F);
    chk("R4 even parity over 7 bits", pb, 1);
    wait_idle();
    cfg_par_odd = 1'b1;
    push_tx(8'hFF, 1'b1);
    cap(7, 1'b1, d, pb, sv);
    chk("R4 odd parity over 7 bits", pb, 0);
    wait_idle();

    // R3: loopback across lengths, upper bits return zero
    for (int l = 0; l < 4; l++) begin
      cfg_len = 2'(l);
      push_tx(8'hE9, 1'b1); push_tx(8'h36, 1'b1); push_tx(8'hFF, 1'b1);
      wait_idle();
    end
    chk("R3 scoreboard drained", expq.size(), 0);

    // R5: start-to-start spacing for each stop code
    cfg_par_en = 1'b0;
    cfg_len = 2'd0; cfg_stop = 2'd0; frame_gap("R5 5-bit one stop", 112);
    cfg_stop = 2'd1;                 frame_gap("R5 5-bit 1.5 stop", 120);
    cfg_len = 2'd3;                  frame_gap("R5 8-bit code1 one stop", 160);
    cfg_stop = 2'd2;                 frame_gap("R5 8-bit two stop", 176);
    cfg_par_en = 1'b1;               frame_gap("R5 8-bit parity two stop", 192);
    cfg_stop = 2'd0;

    // R4/R8: bench-driven frames with errors
    loop = 1'b0; cfg_par_odd = 1'b0;
    expq.push_back({2'b01, 8'h5C}); send_ser(8'h5C, 1'b1, 1'b0);
    expq.push_back({2'b10, 8'h3A}); send_ser(8'h3A, 1'b0, 1'b1);
    expq.push_back({2'b00, 8'hC3}); send_ser(8'hC3, 1'b0, 1'b0);
    wait_idle();
    chk("R8 error entries consumed", expq.size(), 0);

    // R9: short glitch ignored
    drv = 1'b0; repeat (4) @(negedge clk); drv = 1'b1;
    repeat (300) @(negedge clk);
    chk("R9 glitch gives no entry", rx_valid, 0);

    // R7/R10: stalled receive queue and overrun
    rx_ready = 1'b0; ien_rx = 1'b1; cfg_par_en = 1'b0;
    chk("R10 irq low with rx empty", irq, 0);
    for (int i = 0; i < 16; i++) send_ser(8'(i * 7 + 1), 1'b0, 1'b0);
    chk("R10 irq high with rx data", irq, 1);
    chk("R7 no overrun at 16", rx_overrun, 0);
    send_ser(8'hEE, 1'b0, 1'b0);
    chk("R7 overrun set at 17", rx_overrun, 1);
    repeat (20) @(negedge clk);
    chk("R7 overrun sticky", rx_overrun, 1);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    chk("R7 overrun cleared by read", rx_overrun, 0);
    for (int i = 0; i < 16; i++) expq.push_back({2'b00, 8'(i * 7 + 1)});
    rx_ready = 1'b1;
    wait_idle();
    chk("R7 sixteen kept entries matched", expq.size(), 0);
    ien_rx = 1'b0;

    // R6: transmit queue depth with a slow divisor just restarted
    divisor = 16'd1000; @(negedge clk);
    cnt = 0; tx_valid = 1'b1; tx_data = 8'h55;
    for (int i = 0; i < 20; i++) begin
      if (tx_ready) cnt++;
      @(negedge clk);
    end
    tx_valid = 1'b0;
    chk("R6 sixteen bytes accepted", cnt, 16);
    chk("R6 tx_ready low when full", tx_ready, 0);
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R6 tx_empty after flush", tx_empty, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule